// File: doc/BRIEF.md
# FIFO Interrupt Flag and Watermark Unit

This block holds the interrupt register set of a FIFO-based serial controller. It watches the occupancy counts of a transmit FIFO and a receive FIFO, compares them against two programmable watermarks and against the FIFO depth, and latches the results into a sticky status register. Software clears status bits by writing ones back. Two write-only registers, one that only sets and one that only clears, build a read-only mask. A single level interrupt is raised while any latched status bit is also enabled in the mask.

The FIFOs and the serial engine sit outside the block. It has a plain single-cycle register port: a write strobe with address and data, and a combinational read data bus driven from the current address. All four interrupt registers share one 7-bit layout. Bit 2 is TX below watermark, bit 3 is TX full, bit 4 is RX not empty, bit 5 is RX at or above watermark and bit 6 is RX full. Bits 0 and 1 have no source.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: During and right after reset the status and mask read 0x00, irq_o is low, the TX watermark reads 1 and the RX watermark reads 32.
- R2: On the clock edge after tx_level is below the TX watermark, status bit 2 is set. With the watermark at 1 this means the TX FIFO is empty.
- R3: Status bit 3 is set on the edge after tx_level reaches FIFO_DEPTH (63). Status bit 4 is set on the edge after rx_level is nonzero.
- R4: Status bit 5 is set on the edge after rx_level is at or above the RX watermark. Bit 6 is set on the edge after rx_level reaches FIFO_DEPTH. Status bits 0 and 1 are never set.
- R5: A status bit stays set after its condition goes away, until software clears it.
- R6: A write to offset 0x04 clears each status bit whose data bit is 1 and leaves the others unchanged. In the write cycle the clear takes priority over a condition that is still true. That condition sets the bit again on the following edge.
- R7: Writing to offset 0x08 sets each mask bit whose data bit is 1. Data bits of 0 have no effect. Reads of offset 0x08 return 0.
- R8: Writing to offset 0x0C clears each mask bit whose data bit is 1. Data bits of 0 have no effect. Writing 0x7F clears the whole mask.
- R9: irq_o is high exactly when some bit is set in both the status register and the mask register (read at offset 0x10).
- R10: The TX watermark (offset 0x28) and the RX watermark (offset 0x2C) can be written and read back. From the edge after the write, the flags compare against the new value.
- R11: Offset 0x10 is read-only, and writes to it are ignored. Unmapped offsets read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| tx_level | input | LVL_W | Current TX FIFO occupancy |
| rx_level | input | LVL_W | Current RX FIFO occupancy |
| flags_o | output | 7 | Latched status bits |
| irq_o | output | 1 | Level interrupt |

## Verification
Register writes and level changes take effect on the next rising edge. A status bit therefore becomes visible on reg_rdata, flags_o and irq_o one edge after the level or watermark that causes it. Clearing a bit while its condition still holds shows 0 for exactly one cycle. The bench drives inputs at the falling edge and advances a behavioural model at the rising edge. It compares every output at the next falling edge, so each result is sampled in the first cycle it is due. Directed reads are checked a short delay after the address changes, because the read path has no register.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;
    // Shared bit layout of status, enable, disable and mask
    localparam int FLAG_W = 7;
    localparam int BIT_TX_LOW   = 2;
    localparam int BIT_TX_FULL  = 3;
    localparam int BIT_RX_AVAIL = 4;
    localparam int BIT_RX_WM    = 5;
    localparam int BIT_RX_FULL  = 6;

    // Register offsets
    localparam logic [7:0] OFS_STATUS  = 8'h04;
    localparam logic [7:0] OFS_ENABLE  = 8'h08;
    localparam logic [7:0] OFS_DISABLE = 8'h0C;
    localparam logic [7:0] OFS_MASK    = 8'h10;
    localparam logic [7:0] OFS_TX_WM   = 8'h28;
    localparam logic [7:0] OFS_RX_WM   = 8'h2C;
endpackage

// File: rtl/fifo_irq_flag_eval.sv
module fifo_irq_flag_eval
    import fifo_irq_pkg::*;
#(
    parameter int LVL_W      = 7,
    parameter int FIFO_DEPTH = 63
) (
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_wm,
    input  logic [LVL_W-1:0]  rx_wm,
    output logic [FLAG_W-1:0] cond
);
    localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(FIFO_DEPTH);

    always_comb begin
        cond               = '0;
        cond[BIT_TX_LOW]   = tx_level < tx_wm;
        cond[BIT_TX_FULL]  = tx_level >= DEPTH_L;
        cond[BIT_RX_AVAIL] = rx_level != '0;
        cond[BIT_RX_WM]    = rx_level >= rx_wm;
        cond[BIT_RX_FULL]  = rx_level >= DEPTH_L;
    end
endmodule

// File: rtl/fifo_irq_read_mux.sv
module fifo_irq_read_mux
    import fifo_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LVL_W  = 7
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [FLAG_W-1:0] status,
    input  logic [FLAG_W-1:0] mask,
    input  logic [LVL_W-1:0]  tx_wm,
    input  logic [LVL_W-1:0]  rx_wm,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_STATUS))      rdata = DATA_W'(status);
        else if (addr == ADDR_W'(OFS_MASK))   rdata = DATA_W'(mask);
        else if (addr == ADDR_W'(OFS_TX_WM))  rdata = DATA_W'(tx_wm);
        else if (addr == ADDR_W'(OFS_RX_WM))  rdata = DATA_W'(rx_wm);
    end
endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int LVL_W      = 7,
    parameter int FIFO_DEPTH = 63,
    parameter int TX_WM_RST  = 1,
    parameter int RX_WM_RST  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [LVL_W-1:0]  tx_level,
    input  logic [LVL_W-1:0]  rx_level,
    output logic [FLAG_W-1:0] flags_o,
    output logic              irq_o
);
    localparam int USED_W = (LVL_W > FLAG_W) ? LVL_W : FLAG_W;

    typedef struct packed {
        logic [FLAG_W-1:0] status;
        logic [FLAG_W-1:0] mask;
        logic [LVL_W-1:0]  tx_wm;
        logic [LVL_W-1:0]  rx_wm;
    } state_t;

    state_t state_d, state_q;
    logic [FLAG_W-1:0] cond;
    logic unused_wdata_bits;

    assign unused_wdata_bits = ^reg_wdata[DATA_W-1:USED_W];

    fifo_irq_flag_eval #(.LVL_W(LVL_W), .FIFO_DEPTH(FIFO_DEPTH)) u_eval (
        .tx_level (tx_level),
        .rx_level (rx_level),
        .tx_wm    (state_q.tx_wm),
        .rx_wm    (state_q.rx_wm),
        .cond     (cond)
    );

    fifo_irq_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_rmux (
        .addr   (reg_addr),
        .status (state_q.status),
        .mask   (state_q.mask),
        .tx_wm  (state_q.tx_wm),
        .rx_wm  (state_q.rx_wm),
        .rdata  (reg_rdata)
    );

    always_comb begin
        logic [FLAG_W-1:0] wbits;
        wbits   = reg_wdata[FLAG_W-1:0];
        state_d = state_q;
        // sticky capture, clear wins within the write cycle
        state_d.status = state_q.status | cond;
        if (reg_wr && reg_addr == ADDR_W'(OFS_STATUS))
            state_d.status = (state_q.status | cond) & ~wbits;
        if (reg_wr && reg_addr == ADDR_W'(OFS_ENABLE))
            state_d.mask = state_q.mask | wbits;
        if (reg_wr && reg_addr == ADDR_W'(OFS_DISABLE))
            state_d.mask = state_q.mask & ~wbits;
        if (reg_wr && reg_addr == ADDR_W'(OFS_TX_WM))
            state_d.tx_wm = reg_wdata[LVL_W-1:0];
        if (reg_wr && reg_addr == ADDR_W'(OFS_RX_WM))
            state_d.rx_wm = reg_wdata[LVL_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.status <= '0;
            state_q.mask   <= '0;
            state_q.tx_wm  <= LVL_W'(TX_WM_RST);
            state_q.rx_wm  <= LVL_W'(RX_WM_RST);
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o = state_q.status;
    assign irq_o   = |(state_q.status & state_q.mask);

    // Assertions
    assert_reserved_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.status[1:0] == 2'b00);

    assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADDR_W'(OFS_STATUS))
        |=> ((state_q.status & $past(state_q.status)) == $past(state_q.status)));

    assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_ENABLE))
        |=> ((state_q.mask & $past(reg_wdata[FLAG_W-1:0])) == $past(reg_wdata[FLAG_W-1:0])));

    assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_DISABLE))
        |=> ((state_q.mask & $past(reg_wdata[FLAG_W-1:0])) == '0));

    assert_mask_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && (reg_addr == ADDR_W'(OFS_ENABLE) || reg_addr == ADDR_W'(OFS_DISABLE)))
        |=> $stable(state_q.mask));

    assert_txwm_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(OFS_TX_WM))
        |=> (state_q.tx_wm == $past(reg_wdata[LVL_W-1:0])));
endmodule

// File: tb/sim_fifo_irq_ctrl.sv
module sim_fifo_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [6:0]  tx_level = '0;
    logic [6:0]  rx_level = '0;
    logic [6:0]  flags_o;
    logic        irq_o;

    int tests = 0;
    int fails = 0;

    // reference model state
    int m_status = 0, m_mask = 0, m_txwm = 1, m_rxwm = 32;

    always #5 clk = ~clk;

    fifo_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level),
        .rx_level(rx_level), .flags_o(flags_o), .irq_o(irq_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int model_read(logic [7:0] a);
        case (a)
            8'h04:   return m_status;
            8'h10:   return m_mask;
            8'h28:   return m_txwm;
            8'h2C:   return m_rxwm;
            default: return 0;
        endcase
    endfunction

    function automatic int conditions();
        int c = 0;
        if (int'(tx_level) < m_txwm) c |= 'h04;
        if (int'(tx_level) >= 63)    c |= 'h08;
        if (int'(rx_level) != 0)     c |= 'h10;
        if (int'(rx_level) >= m_rxwm) c |= 'h20;
        if (int'(rx_level) >= 63)    c |= 'h40;
        return c;
    endfunction

    task automatic model_step();
        int c, w;
        if (!rst_n) begin
            m_status = 0; m_mask = 0; m_txwm = 1; m_rxwm = 32;
            return;
        end
        c = conditions();
        w = int'(reg_wdata[6:0]);
        m_status = m_status | c;
        if (reg_wr) begin
            case (reg_addr)
                8'h04: m_status = m_status & ~w;
                8'h08: m_mask = m_mask | w;
                8'h0C: m_mask = m_mask & ~w;
                8'h28: m_txwm = w;
                8'h2C: m_rxwm = w;
                default: ;
            endcase
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        check("R9 irq", {31'b0, irq_o}, ((m_status & m_mask) != 0) ? 32'd1 : 32'd0);
        check("R5 flags", {25'b0, flags_o}, 32'(m_status));
        check("R11 rdata", reg_rdata, 32'(model_read(reg_addr)));
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick(); tick();
        rd(8'h04, 32'h00, "R1 status reset");
        rd(8'h10, 32'h00, "R1 mask reset");
        rd(8'h28, 32'd1,  "R1 tx watermark reset");
        rd(8'h2C, 32'd32, "R1 rx watermark reset");
        check("R1 irq reset", {31'b0, irq_o}, 32'd0);
        rst_n = 1'b1;
        rd(8'h04, 32'h00, "R1 status after release");
        tick();
        rd(8'h04, 32'h04, "R2 tx empty flag");

        tx_level = 7'd5;
        tick(); tick();
        rd(8'h04, 32'h04, "R5 sticky after condition gone");
        wr(8'h04, 32'h00);
        rd(8'h04, 32'h04, "R6 zero write keeps bit");
        wr(8'h04, 32'h04);
        rd(8'h04, 32'h00, "R6 w1c clears");

        tx_level = 7'd0;
        wr(8'h04, 32'h04);
        rd(8'h04, 32'h00, "R6 clear wins in write cycle");
        tick();
        rd(8'h04, 32'h04, "R6 re-set next cycle");

        tx_level = 7'd63;
        tick();
        rd(8'h04, 32'h0C, "R3 tx full");
        rx_level = 7'd1;
        tick();
        rd(8'h04, 32'h1C, "R3 rx not empty");

        tx_level = 7'd5; rx_level = 7'd0;
        wr(8'h04, 32'h7F);
        rd(8'h04, 32'h00, "R6 clear all");
        rx_level = 7'd32;
        tick();
        rd(8'h04, 32'h30, "R4 rx watermark reached");
        rx_level = 7'd63;
        tick();
        rd(8'h04, 32'h70, "R4 rx full");
        rx_level = 7'd0;
        wr(8'h04, 32'h7F);
        rx_level = 7'd31;
        tick();
        rd(8'h04, 32'h10, "R4 below rx watermark");
        check("R9 irq off with empty mask", {31'b0, irq_o}, 32'd0);

        wr(8'h08, 32'h14);
        rd(8'h10, 32'h14, "R7 enable sets mask");
        check("R9 irq on", {31'b0, irq_o}, 32'd1);
        rd(8'h08, 32'h00, "R7 enable reads zero");
        wr(8'h08, 32'h00);
        rd(8'h10, 32'h14, "R7 zero enable no effect");
        wr(8'h0C, 32'h10);
        rd(8'h10, 32'h04, "R8 disable clears bit");
        check("R9 irq off when masked", {31'b0, irq_o}, 32'd0);
        wr(8'h0C, 32'h00);
        rd(8'h10, 32'h04, "R8 zero disable no effect");
        wr(8'h08, 32'h7F);
        check("R9 irq all enabled", {31'b0, irq_o}, 32'd1);
        wr(8'h0C, 32'h7F);
        rd(8'h10, 32'h00, "R8 disable all");

        wr(8'h28, 32'd10);
        rd(8'h28, 32'd10, "R10 tx watermark readback");
        rd(8'h04, 32'h10, "R10 old watermark in write cycle");
        tick();
        rd(8'h04, 32'h14, "R10 new tx watermark applies");
        wr(8'h2C, 32'd4);
        rd(8'h2C, 32'd4, "R10 rx watermark readback");
        tick();
        rd(8'h04, 32'h34, "R10 new rx watermark applies");

        wr(8'h10, 32'h7F);
        rd(8'h10, 32'h00, "R11 mask read-only");
        wr(8'h40, 32'hFFFF_FFFF);
        rd(8'h40, 32'h00, "R11 unmapped reads zero");
        rd(8'h28, 32'd10, "R11 unmapped write ignored");
        rd(8'h10, 32'h00, "R11 unmapped write leaves mask");
        tick();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule